// File: doc/BRIEF.md
# Interruption Entry Sequencer

This block carries out the state changes a processor core makes when it takes a trap, a fault or an external interrupt. When it accepts an event, it saves the current status word and both instruction address queue entries into the interruption control registers. It loads a cleared status word and points the address queue at the handler slot, which is the vector base plus 32 bytes times the event code. If state saving is enabled in the old status word, it also records the instruction word of the event and copies seven general registers into shadow registers.

Depending on the class of the event, the instruction word comes from one of three places. It can come from a value the decoder supplies, or from a single-word physical memory read of the faulting instruction, or it can be left as it was. The memory read uses a valid/ready request channel and a valid-only response channel. An external interrupt request competes with synchronous events for entry. While a sequence is running the block shows busy, and it ends each sequence with a one-cycle done pulse. At that point the new status word and the new address queue values are valid on the outputs.

Top module: `intr_entry_seq`

## Requirements
- R1: On accepting an event, the interruption status register (`ipsw_o`) takes the complete status word `psw_i` as it was in the accepting cycle.
- R2: The new status word `psw_o` is zero in every bit except two. Bit 27 equals `wide_mode_i`. Bit 4 is 1 only when the accepted code is 1.
- R3: The interruption address registers take the front address (`iiaoq_f_o` ← `iaoq_f_i`) and the back address (`iiaoq_b_o` ← `iaoq_b_i`) of the accepting cycle.
- R4: When bit 3 (the state-save bit) of the old status word is 0, `iir_o` and all shadow registers keep their previous values, and no memory read is issued.
- R5: With the save bit at 1, codes 8, 9, 10 and 11 load `iir_o` from `dec_insn_i`.
- R6: With the save bit at 1, the codes in the set 12–22 and 26–28 issue a memory read at the front address with bits 1:0 forced to 0. The request valid and the address are held until ready. `iir_o` then takes the response data.
- R7: With the save bit at 1, any other code leaves `iir_o` unchanged and issues no memory read.
- R8: With the save bit at 1, shadow registers 0 to 6 take general registers 1, 8, 9, 16, 17, 24 and 25 respectively.
- R9: The new front address `iaoq_f_o` equals `iva_i` + 32 × code, and `iaoq_b_o` equals `iaoq_f_o` + 4.
- R10: An external interrupt is accepted only when `hard_irq_i` is 1 and status bit 0 (the interrupt enable) is 1. It enters with code 4.
- R11: When a synchronous event (`exc_valid_i`) and an acceptable external interrupt are present together, the synchronous event's code is taken.
- R12: While `busy_o` is 1, new requests are ignored. Each sequence ends with `done_o` high for exactly one cycle, and the block is idle in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | Synchronous event request |
| exc_code_i | input | 6 | Synchronous event code |
| hard_irq_i | input | 1 | External interrupt request line |
| psw_i | input | XLEN | Current status word |
| iaoq_f_i | input | XLEN | Front instruction address |
| iaoq_b_i | input | XLEN | Back instruction address |
| iva_i | input | XLEN | Interruption vector base |
| wide_mode_i | input | 1 | Wide-mode configuration bit |
| dec_insn_i | input | XLEN | Instruction word from the decoder |
| gr_i | input | NUM_GR*XLEN | General registers, register k at bits k*XLEN |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory read request accepted |
| mem_req_addr_o | output | XLEN | Word-aligned read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | XLEN | Read data |
| ipsw_o | output | XLEN | Saved status word |
| iiaoq_f_o | output | XLEN | Saved front address |
| iiaoq_b_o | output | XLEN | Saved back address |
| iir_o | output | XLEN | Saved instruction word |
| shadow_o | output | 7*XLEN | Shadow registers, shadow k at bits k*XLEN |
| psw_o | output | XLEN | New status word |
| iaoq_f_o | output | XLEN | Handler front address |
| iaoq_b_o | output | XLEN | Handler back address |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, assertions check the following:
- the done pulse lasts one cycle;
- a memory request holds and stays word-aligned until it is accepted;
- the new status word clears every bit except the wide-mode and machine-check bits;
- the back handler address follows the front by four;
- the saved state does not move while the block is busy or when the save bit is clear.

Other properties need the bench's directed scenarios, because they depend on outside data or ordering:
- which source loads the instruction word for each code class;
- the mapping from general registers to shadow registers;
- the vector arithmetic;
- the gating of external interrupts by the enable bit;
- the priority of synchronous events over external interrupts.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int unsigned CODE_W     = 6;
  localparam int unsigned NUM_SHADOW = 7;
  localparam logic [CODE_W-1:0] CODE_MCHK = 6'd1;
  localparam logic [CODE_W-1:0] CODE_EXT  = 6'd4;

  typedef enum logic [1:0] {IIR_KEEP, IIR_DECODE, IIR_FETCH} iir_src_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} seq_state_e;

  function automatic int unsigned shadow_src(int unsigned k);
    case (k)
      0: return 1;
      1: return 8;
      2: return 9;
      3: return 16;
      4: return 17;
      5: return 24;
      default: return 25;
    endcase
  endfunction
endpackage

// File: rtl/intr_classify.sv
module intr_classify
  import intr_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output iir_src_e          src_o
);
  always_comb begin
    case (code_i)
      6'd8, 6'd9, 6'd10, 6'd11:                        src_o = IIR_DECODE;
      6'd12, 6'd13, 6'd14, 6'd15, 6'd16, 6'd17, 6'd18,
      6'd19, 6'd20, 6'd21, 6'd22, 6'd26, 6'd27, 6'd28: src_o = IIR_FETCH;
      default:                                         src_o = IIR_KEEP;
    endcase
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_seq_pkg::*;
(
  input  logic              idle_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              hard_irq_i,
  input  logic              irq_en_i,
  output logic              accept_o,
  output logic [CODE_W-1:0] code_o
);
  logic ext_ok;
  assign ext_ok   = hard_irq_i & irq_en_i;
  assign accept_o = idle_i & (exc_valid_i | ext_ok);
  // synchronous events win over the external line
  assign code_o   = exc_valid_i ? exc_code_i : CODE_EXT;
endmodule

// File: rtl/intr_shadow_bank.sv
module intr_shadow_bank
  import intr_seq_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned NUM_GR = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [NUM_GR*XLEN-1:0]   gr_i,
  output logic [NUM_SHADOW*XLEN-1:0] shadow_o
);
  for (genvar k = 0; k < NUM_SHADOW; k++) begin : g_sh
    localparam int unsigned SRC = shadow_src(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   shadow_o[k*XLEN +: XLEN] <= '0;
      else if (we_i) shadow_o[k*XLEN +: XLEN] <= gr_i[SRC*XLEN +: XLEN];
    end
  end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_seq_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NUM_GR   = 32,
  parameter int unsigned PSW_I    = 0,
  parameter int unsigned PSW_Q    = 3,
  parameter int unsigned PSW_M    = 4,
  parameter int unsigned PSW_W    = 27,
  parameter int unsigned SLOT_LG2 = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        exc_valid_i,
  input  logic [CODE_W-1:0]           exc_code_i,
  input  logic                        hard_irq_i,
  input  logic [XLEN-1:0]             psw_i,
  input  logic [XLEN-1:0]             iaoq_f_i,
  input  logic [XLEN-1:0]             iaoq_b_i,
  input  logic [XLEN-1:0]             iva_i,
  input  logic                        wide_mode_i,
  input  logic [XLEN-1:0]             dec_insn_i,
  input  logic [NUM_GR*XLEN-1:0]      gr_i,
  output logic                        mem_req_valid_o,
  input  logic                        mem_req_ready_i,
  output logic [XLEN-1:0]             mem_req_addr_o,
  input  logic                        mem_rsp_valid_i,
  input  logic [XLEN-1:0]             mem_rsp_data_i,
  output logic [XLEN-1:0]             ipsw_o,
  output logic [XLEN-1:0]             iiaoq_f_o,
  output logic [XLEN-1:0]             iiaoq_b_o,
  output logic [XLEN-1:0]             iir_o,
  output logic [NUM_SHADOW*XLEN-1:0]  shadow_o,
  output logic [XLEN-1:0]             psw_o,
  output logic [XLEN-1:0]             iaoq_f_o,
  output logic [XLEN-1:0]             iaoq_b_o,
  output logic                        busy_o,
  output logic                        done_o
);
  localparam logic [XLEN-1:0] KEEP_MASK = (XLEN'(1) << PSW_W) | (XLEN'(1) << PSW_M);

  seq_state_e        state_q;
  logic              accept;
  logic [CODE_W-1:0] code_sel;
  iir_src_e          src;
  logic              save_en;
  logic [XLEN-1:0]   psw_new;
  logic [XLEN-1:0]   vec_addr;

  intr_arbiter u_arb (
    .idle_i      (state_q == ST_IDLE),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .hard_irq_i  (hard_irq_i),
    .irq_en_i    (psw_i[PSW_I]),
    .accept_o    (accept),
    .code_o      (code_sel)
  );

  intr_classify u_cls (
    .code_i (code_sel),
    .src_o  (src)
  );

  assign save_en = accept & psw_i[PSW_Q];

  intr_shadow_bank #(.XLEN(XLEN), .NUM_GR(NUM_GR)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (save_en),
    .gr_i     (gr_i),
    .shadow_o (shadow_o)
  );

  always_comb begin
    psw_new        = '0;
    psw_new[PSW_W] = wide_mode_i;
    psw_new[PSW_M] = (code_sel == CODE_MCHK);
  end

  assign vec_addr = iva_i + (XLEN'(code_sel) << SLOT_LG2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      ipsw_o         <= '0;
      iiaoq_f_o      <= '0;
      iiaoq_b_o      <= '0;
      iir_o          <= '0;
      psw_o          <= '0;
      iaoq_f_o       <= '0;
      iaoq_b_o       <= '0;
      mem_req_addr_o <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          ipsw_o         <= psw_i;
          iiaoq_f_o      <= iaoq_f_i;
          iiaoq_b_o      <= iaoq_b_i;
          psw_o          <= psw_new;
          iaoq_f_o       <= vec_addr;
          iaoq_b_o       <= vec_addr + XLEN'(4);
          mem_req_addr_o <= {iaoq_f_i[XLEN-1:2], 2'b00};
          if (save_en && src == IIR_DECODE) iir_o <= dec_insn_i;
          state_q <= (save_en && src == IIR_FETCH) ? ST_REQ : ST_DONE;
        end
        ST_REQ:  if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          iir_o   <= mem_rsp_data_i;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (state_q == ST_REQ);
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = (state_q == ST_DONE);

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ipsw_o) && $stable(iaoq_f_o));
  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  // R6
  req_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o[1:0] == 2'b00);
  // R2
  psw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (psw_o & ~KEEP_MASK) == '0);
  // R9
  back_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> iaoq_b_o == iaoq_f_o + XLEN'(4));
  // R4
  no_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !psw_i[PSW_Q] |=> $stable(shadow_o) && $stable(iir_o) && !mem_req_valid_o);
endmodule

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb;
  localparam int XLEN = 32;
  localparam int NGR  = 32;

  logic clk = 0, rst_n = 0;
  logic exc_valid = 0, hard_irq = 0, wide = 0;
  logic [5:0] exc_code = '0;
  logic [31:0] psw = '0, iaq_f = '0, iaq_b = '0, iva = '0, dec = '0;
  logic [NGR*XLEN-1:0] gr = '0;
  logic req_ready = 0, rsp_valid = 0;
  logic [31:0] rsp_data = '0;
  logic req_valid, busy, done;
  logic [31:0] req_addr, ipsw, iiq_f, iiq_b, iir, npsw, nq_f, nq_b;
  logic [7*XLEN-1:0] shadow;

  int n_chk = 0, n_err = 0;
  logic [31:0] m_iir = '0;
  logic [31:0] m_sh [7];
  int sh_idx [7] = '{1, 8, 9, 16, 17, 24, 25};

  always #10 clk = ~clk;

  intr_entry_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(exc_valid), .exc_code_i(exc_code),
    .hard_irq_i(hard_irq), .psw_i(psw), .iaoq_f_i(iaq_f), .iaoq_b_i(iaq_b),
    .iva_i(iva), .wide_mode_i(wide), .dec_insn_i(dec), .gr_i(gr),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .ipsw_o(ipsw), .iiaoq_f_o(iiq_f), .iiaoq_b_o(iiq_b), .iir_o(iir), .shadow_o(shadow),
    .psw_o(npsw), .iaoq_f_o(nq_f), .iaoq_b_o(nq_b), .busy_o(busy), .done_o(done)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_gr(logic [31:0] seed);
    for (int i = 0; i < NGR; i++) gr[i*XLEN +: XLEN] = seed ^ (i * 32'h0101_0101);
  endtask

  task automatic model_shadow();
    for (int k = 0; k < 7; k++) m_sh[k] = gr[sh_idx[k]*XLEN +: XLEN];
  endtask

  // one accept edge; returns at the negedge right after it
  task automatic launch(logic sync, logic [5:0] code);
    @(negedge clk);
    exc_valid = sync; exc_code = code;
    if (!sync) hard_irq = 1;
    @(negedge clk);
    exc_valid = 0; hard_irq = 0;
  endtask

  task automatic serve_fetch(logic [31:0] exp_addr, logic [31:0] data, string req);
    chk(req, "req valid", {31'd0, req_valid}, 32'd1);
    chk(req, "req addr", req_addr, exp_addr);
    repeat (2) begin
      @(negedge clk);
      chk(req, "req held", {31'd0, req_valid}, 32'd1);
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0; rsp_valid = 1; rsp_data = data;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic wait_done(string req);
    for (int i = 0; i < 10 && !done; i++) @(negedge clk);
    chk(req, "done", {31'd0, done}, 32'd1);
  endtask

  task automatic check_entry(logic [5:0] code, logic [31:0] old_psw, logic [31:0] f,
                             logic [31:0] b, logic [31:0] base, logic wd);
    logic [31:0] ep;
    ep = '0; ep[27] = wd; ep[4] = (code == 6'd1);
    chk("R1", "ipsw", ipsw, old_psw);
    chk("R2", "new psw", npsw, ep);
    chk("R3", "saved front", iiq_f, f);
    chk("R3", "saved back", iiq_b, b);
    chk("R9", "handler front", nq_f, base + 32 * code);
    chk("R9", "handler back", nq_b, base + 32 * code + 4);
    chk("R5/R6/R7 iir", "iir", iir, m_iir);
    for (int k = 0; k < 7; k++) chk("R8", "shadow", shadow[k*XLEN +: XLEN], m_sh[k]);
    @(negedge clk);
    chk("R12", "done low after pulse", {31'd0, done}, 32'd0);
    chk("R12", "idle after done", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R12", "reset busy", {31'd0, busy}, 32'd0);
    chk("R12", "reset done", {31'd0, done}, 32'd0);
    chk("R6", "reset req", {31'd0, req_valid}, 32'd0);
    chk("R2", "reset psw", npsw, 32'd0);
    for (int k = 0; k < 7; k++) m_sh[k] = '0;
  endtask

  task automatic t_decode();  // R5 R8
    psw = 32'h8A00_00FF; iaq_f = 32'h0000_4003; iaq_b = 32'h0000_4007;
    iva = 32'h0010_0000; dec = 32'hDEAD_0008; wide = 0; set_gr(32'h1111_0000);
    m_iir = dec; model_shadow();
    launch(1, 6'd8);
    wait_done("R5");
    check_entry(6'd8, psw, iaq_f, iaq_b, iva, 0);
  endtask

  task automatic t_fetch();  // R6
    psw = 32'h0000_0008; iaq_f = 32'h0000_8123; iaq_b = 32'h0000_8127;
    iva = 32'h0020_0000; set_gr(32'h2222_0000); model_shadow();
    launch(1, 6'd15);
    serve_fetch(32'h0000_8120, 32'hCAFE_F00D, "R6");
    m_iir = 32'hCAFE_F00D;
    wait_done("R6");
    check_entry(6'd15, psw, iaq_f, iaq_b, iva, 0);
  endtask

  task automatic t_other_mchk();  // R7 R2
    psw = 32'h0000_0009; iaq_f = 32'h0000_9000; iaq_b = 32'h0000_9004;
    iva = 32'h0030_0000; wide = 1; dec = 32'h5555_5555; set_gr(32'h3333_0000); model_shadow();
    launch(1, 6'd1);
    chk("R7", "no mem req", {31'd0, req_valid}, 32'd0);
    wait_done("R7");
    check_entry(6'd1, psw, iaq_f, iaq_b, iva, 1);
    wide = 0;
  endtask

  task automatic t_no_save();  // R4
    psw = 32'h0000_0001; iaq_f = 32'h0000_A000; iaq_b = 32'h0000_A004;
    iva = 32'h0040_0000; dec = 32'h7777_7777; set_gr(32'h4444_0000);
    launch(1, 6'd12);
    chk("R4", "no mem req", {31'd0, req_valid}, 32'd0);
    wait_done("R4");
    check_entry(6'd12, psw, iaq_f, iaq_b, iva, 0);
  endtask

  task automatic t_ext_masked();  // R10
    logic [31:0] prev;
    prev = ipsw;
    psw = 32'h0000_0008; hard_irq = 1;
    repeat (4) @(negedge clk);
    chk("R10", "masked irq busy", {31'd0, busy}, 32'd0);
    chk("R10", "masked irq ipsw", ipsw, prev);
    hard_irq = 0;
  endtask

  task automatic t_ext_taken();  // R10
    psw = 32'h0000_0009; iaq_f = 32'h0000_B000; iaq_b = 32'h0000_B004;
    iva = 32'h0050_0000; set_gr(32'h5555_0000); model_shadow();
    launch(0, 6'd0);
    wait_done("R10");
    check_entry(6'd4, psw, iaq_f, iaq_b, iva, 0);
  endtask

  task automatic t_priority();  // R11
    psw = 32'h0000_0009; iaq_f = 32'h0000_C002; iaq_b = 32'h0000_C006;
    iva = 32'h0060_0000; set_gr(32'h6666_0000); model_shadow();
    @(negedge clk);
    exc_valid = 1; exc_code = 6'd12; hard_irq = 1;
    @(negedge clk);
    exc_valid = 0; hard_irq = 0;
    serve_fetch(32'h0000_C000, 32'h1234_5678, "R11");
    m_iir = 32'h1234_5678;
    wait_done("R11");
    check_entry(6'd12, psw, iaq_f, iaq_b, iva, 0);
  endtask

  task automatic t_busy_ignore();  // R12
    psw = 32'h0000_0008; iaq_f = 32'h0000_D000; iaq_b = 32'h0000_D004;
    iva = 32'h0070_0000; set_gr(32'h7777_0000); model_shadow();
    launch(1, 6'd28);
    exc_valid = 1; exc_code = 6'd2;
    @(negedge clk);
    exc_valid = 0;
    chk("R12", "busy during fetch", {31'd0, busy}, 32'd1);
    serve_fetch(32'h0000_D000, 32'h0BAD_CAFE, "R12");
    m_iir = 32'h0BAD_CAFE;
    wait_done("R12");
    check_entry(6'd28, psw, iaq_f, iaq_b, iva, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_decode();
    t_fetch();
    t_other_mchk();
    t_no_save();
    t_ext_masked();
    t_ext_taken();
    t_priority();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R12: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule